// File: doc/BRIEF.md
# Exception Detection and Vector Encoder

This block sits beside the execute stage of a processor core. Every cycle it samples a set of condition strobes: arithmetic faults, trap requests, decode faults, coprocessor status, a software interrupt request with its vector, a non-maskable interrupt and a maskable request with its vector. When at least one condition is present, it chooses the winner by a fixed priority. One cycle later it presents the interrupt vector number together with a flag. The flag tells the control unit whether the saved return address must point back at the faulting instruction, so that it is executed again, or at the instruction that follows.

Every condition input is a one-cycle strobe that belongs to the cycle in which it is high. The outputs are plain control pins with no handshake. The consumer must act on `take_o` in the cycle in which it is high, and no back-pressure is possible. Between events, `vec_o` and `restart_o` keep the last delivered values. Reading the handler table and dispatching to the handler belong to other blocks.

Top module: `exc_vector_unit`

## Requirements
- R1: A cycle with `div_zero_i` or `quot_ovf_i` high yields vector 0 with `restart_o` = 1.
- R2: `step_trap_i` yields vector 1 and `brk_trap_i` yields vector 3, both with `restart_o` = 0.
- R3: `into_exec_i` with `of_flag_i` = 1 yields vector 4 with `restart_o` = 0. With `of_flag_i` = 0 it raises nothing, so `take_o` stays 0.
- R4: `bound_fail_i` yields vector 5 and `bad_opcode_i` yields vector 6, both with `restart_o` = 1.
- R5: `cop_absent_i` (coprocessor not available) yields vector 7 and `limit_fault_i` (INT vector beyond the table limit) yields vector 8, both with `restart_o` = 1.
- R6: `word_wrap_i` (word access at offset FFFFh, or execution past the segment end) yields vector 13 with `restart_o` = 1.
- R7: `cop_error_i` yields vector 16 with `restart_o` = 1.
- R8: `sw_int_i` yields the vector on `sw_vec_i` with `restart_o` = 0.
- R9: `nmi_i` yields vector 2 with `restart_o` = 0, whatever the value of `if_flag_i`.
- R10: `intr_req_i` yields the vector on `intr_vec_i` with `restart_o` = 0, but only when `if_flag_i` = 1. When `if_flag_i` = 0 the request has no effect and `take_o` stays 0.
- R11: When several conditions share a cycle, the winner follows this order, highest first: divide, step, breakpoint, INTO, BOUND, opcode, coprocessor absent, table limit, word wrap, coprocessor error, software INT, NMI, maskable request.
- R12: `take_o` is high in exactly the cycle after a cycle with a qualifying condition, and low otherwise. `vec_o` and `restart_o` change only together with `take_o`. After reset all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_zero_i | input | 1 | Divide with zero denominator |
| quot_ovf_i | input | 1 | Quotient too large for destination |
| step_trap_i | input | 1 | Single-step trap request |
| brk_trap_i | input | 1 | Breakpoint instruction executed |
| into_exec_i | input | 1 | INTO instruction executed |
| of_flag_i | input | 1 | Current overflow flag |
| bound_fail_i | input | 1 | BOUND index outside limits |
| bad_opcode_i | input | 1 | Undefined opcode |
| cop_absent_i | input | 1 | Coprocessor not available |
| limit_fault_i | input | 1 | INT vector beyond table limit |
| word_wrap_i | input | 1 | Word at offset FFFFh or past segment end |
| cop_error_i | input | 1 | Coprocessor error |
| sw_int_i | input | 1 | Software INT executed |
| sw_vec_i | input | VEC_W | Software INT vector |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_req_i | input | 1 | Maskable interrupt request |
| intr_vec_i | input | VEC_W | Maskable request vector |
| if_flag_i | input | 1 | Interrupt-enable flag |
| take_o | output | 1 | One-cycle interrupt-taken pulse |
| vec_o | output | VEC_W | Vector number |
| restart_o | output | 1 | 1: return to faulting instruction |

## Verification
Each condition is first driven on its own, which pins down its vector number and its restart rule. The gated inputs are then driven with their gate open and with it closed. INTO is tried with the overflow flag clear, and the maskable request with the enable flag clear, to show that the gate qualifies them. NMI is tried with the enable flag clear, to show that it ignores the flag. Pairs and triples of conditions in one cycle check the order between the groups and inside the internal group. Long sparse random mixes then compare vector, restart and pulse against the model on every cycle, including the empty cycles in which the outputs must hold.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VEC_W_DEF = 8;

  // source index doubles as priority: lower index wins
  typedef enum logic [3:0] {
    S_DIV    = 4'd0,
    S_STEP   = 4'd1,
    S_BRK    = 4'd2,
    S_INTO   = 4'd3,
    S_BOUND  = 4'd4,
    S_OPC    = 4'd5,
    S_NOCOP  = 4'd6,
    S_LIMIT  = 4'd7,
    S_WRAP   = 4'd8,
    S_COPERR = 4'd9,
    S_SWINT  = 4'd10,
    S_NMI    = 4'd11,
    S_INTR   = 4'd12
  } src_e;

  localparam int NSRC  = 13;
  localparam int IDX_W = $clog2(NSRC);

  function automatic logic [7:0] fixed_vec(input src_e s);
    case (s)
      S_DIV:    fixed_vec = 8'd0;
      S_STEP:   fixed_vec = 8'd1;
      S_BRK:    fixed_vec = 8'd3;
      S_INTO:   fixed_vec = 8'd4;
      S_BOUND:  fixed_vec = 8'd5;
      S_OPC:    fixed_vec = 8'd6;
      S_NOCOP:  fixed_vec = 8'd7;
      S_LIMIT:  fixed_vec = 8'd8;
      S_WRAP:   fixed_vec = 8'd13;
      S_COPERR: fixed_vec = 8'd16;
      S_NMI:    fixed_vec = 8'd2;
      default:  fixed_vec = 8'd0;
    endcase
  endfunction

  function automatic logic restarts(input src_e s);
    case (s)
      S_DIV, S_BOUND, S_OPC, S_NOCOP, S_LIMIT, S_WRAP, S_COPERR: restarts = 1'b1;
      default: restarts = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/exc_req_collect.sv
module exc_req_collect
  import exc_pkg::*;
(
  input  logic            div_zero_i,
  input  logic            quot_ovf_i,
  input  logic            step_trap_i,
  input  logic            brk_trap_i,
  input  logic            into_exec_i,
  input  logic            of_flag_i,
  input  logic            bound_fail_i,
  input  logic            bad_opcode_i,
  input  logic            cop_absent_i,
  input  logic            limit_fault_i,
  input  logic            word_wrap_i,
  input  logic            cop_error_i,
  input  logic            sw_int_i,
  input  logic            nmi_i,
  input  logic            intr_req_i,
  input  logic            if_flag_i,
  output logic [NSRC-1:0] req_o
);
  always_comb begin
    req_o           = '0;
    req_o[S_DIV]    = div_zero_i | quot_ovf_i;
    req_o[S_STEP]   = step_trap_i;
    req_o[S_BRK]    = brk_trap_i;
    req_o[S_INTO]   = into_exec_i & of_flag_i;
    req_o[S_BOUND]  = bound_fail_i;
    req_o[S_OPC]    = bad_opcode_i;
    req_o[S_NOCOP]  = cop_absent_i;
    req_o[S_LIMIT]  = limit_fault_i;
    req_o[S_WRAP]   = word_wrap_i;
    req_o[S_COPERR] = cop_error_i;
    req_o[S_SWINT]  = sw_int_i;
    req_o[S_NMI]    = nmi_i;
    req_o[S_INTR]   = intr_req_i & if_flag_i;
  end
endmodule

// File: rtl/exc_prio_pick.sv
module exc_prio_pick #(
  parameter int N  = 13,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  grant_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] lower_any;
  assign lower_any[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign lower_any[i+1] = lower_any[i] | req_i[i];
    assign grant_o[i]     = req_i[i] & ~lower_any[i];
  end

  assign any_o = lower_any[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++)
      if (grant_o[i]) idx_o = IW'(i);
  end
endmodule

// File: rtl/exc_out_reg.sv
module exc_out_reg
  import exc_pkg::*;
#(
  parameter int VEC_W = VEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  input  logic [VEC_W-1:0] intr_vec_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             restart_o
);
  src_e             win;
  logic [VEC_W-1:0] vec_nxt;

  assign win = src_e'(idx_i);

  always_comb begin
    case (win)
      S_SWINT: vec_nxt = sw_vec_i;
      S_INTR:  vec_nxt = intr_vec_i;
      default: vec_nxt = VEC_W'(fixed_vec(win));
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_o    <= 1'b0;
      vec_o     <= '0;
      restart_o <= 1'b0;
    end else begin
      take_o <= any_i;
      if (any_i) begin
        vec_o     <= vec_nxt;
        restart_o <= restarts(win);
      end
    end
  end
endmodule

// File: rtl/exc_vector_unit.sv
module exc_vector_unit
  import exc_pkg::*;
#(
  parameter int VEC_W = VEC_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_zero_i,
  input  logic             quot_ovf_i,
  input  logic             step_trap_i,
  input  logic             brk_trap_i,
  input  logic             into_exec_i,
  input  logic             of_flag_i,
  input  logic             bound_fail_i,
  input  logic             bad_opcode_i,
  input  logic             cop_absent_i,
  input  logic             limit_fault_i,
  input  logic             word_wrap_i,
  input  logic             cop_error_i,
  input  logic             sw_int_i,
  input  logic [VEC_W-1:0] sw_vec_i,
  input  logic             nmi_i,
  input  logic             intr_req_i,
  input  logic [VEC_W-1:0] intr_vec_i,
  input  logic             if_flag_i,
  output logic             take_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             restart_o
);
  logic [NSRC-1:0]  req;
  logic [NSRC-1:0]  grant;
  logic [IDX_W-1:0] idx;
  logic             any;

  exc_req_collect u_collect (
    .div_zero_i, .quot_ovf_i, .step_trap_i, .brk_trap_i, .into_exec_i,
    .of_flag_i, .bound_fail_i, .bad_opcode_i, .cop_absent_i,
    .limit_fault_i, .word_wrap_i, .cop_error_i, .sw_int_i, .nmi_i,
    .intr_req_i, .if_flag_i, .req_o(req)
  );

  exc_prio_pick #(.N(NSRC), .IW(IDX_W)) u_pick (
    .req_i(req), .grant_o(grant), .idx_o(idx), .any_o(any)
  );

  exc_out_reg #(.VEC_W(VEC_W)) u_out (
    .clk, .rst_n, .any_i(any), .idx_i(idx), .sw_vec_i, .intr_vec_i,
    .take_o, .vec_o, .restart_o
  );

  // assertions, relating pins across the register stage
  logic internal_any;
  assign internal_any = |req[S_SWINT:0];

  p_onehot_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_divide_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_zero_i | quot_ovf_i) |=> (take_o && vec_o == '0 && restart_o));

  p_nmi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_i && !internal_any) |=> (take_o && vec_o == VEC_W'(2) && !restart_o));

  p_if_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_flag_i && !nmi_i && !internal_any) |=> !take_o);

  p_into_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (into_exec_i && !of_flag_i && !nmi_i && !(intr_req_i && if_flag_i) &&
     !(|req[S_SWINT:0])) |=> !take_o);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> ($stable(vec_o) && $stable(restart_o)));

  p_trap_norestart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && (vec_o == VEC_W'(1) || vec_o == VEC_W'(3) || vec_o == VEC_W'(4)))
      |-> !restart_o);
endmodule

// File: tb/exc_vector_unit_test.sv
module exc_vector_unit_test;
  localparam int CLK_P = 10;
  localparam int WD_CYC = 20000;

  logic clk = 0, rst_n = 0;
  logic div_zero, quot_ovf, step_trap, brk_trap, into_exec, of_flag;
  logic bound_fail, bad_opcode, cop_absent, limit_fault, word_wrap, cop_error;
  logic sw_int, nmi, intr_req, if_flag;
  logic [7:0] sw_vec, intr_vec;
  logic take;
  logic [7:0] vec;
  logic restart;

  int checks = 0, fails = 0;
  bit done = 0;
  bit e_take = 0, e_rst = 0;
  int e_vec = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_vector_unit uut (
    .clk, .rst_n, .div_zero_i(div_zero), .quot_ovf_i(quot_ovf),
    .step_trap_i(step_trap), .brk_trap_i(brk_trap), .into_exec_i(into_exec),
    .of_flag_i(of_flag), .bound_fail_i(bound_fail), .bad_opcode_i(bad_opcode),
    .cop_absent_i(cop_absent), .limit_fault_i(limit_fault),
    .word_wrap_i(word_wrap), .cop_error_i(cop_error), .sw_int_i(sw_int),
    .sw_vec_i(sw_vec), .nmi_i(nmi), .intr_req_i(intr_req),
    .intr_vec_i(intr_vec), .if_flag_i(if_flag),
    .take_o(take), .vec_o(vec), .restart_o(restart)
  );

  task automatic clear();
    {div_zero, quot_ovf, step_trap, brk_trap, into_exec, of_flag} = '0;
    {bound_fail, bad_opcode, cop_absent, limit_fault, word_wrap, cop_error} = '0;
    {sw_int, nmi, intr_req, if_flag} = '0;
    sw_vec = 8'h40; intr_vec = 8'h21;
  endtask

  // reference model: evaluate the listed priority on the current inputs
  task automatic model();
    bit t = 1; int v = 0; bit r = 0;
    if (div_zero || quot_ovf)     begin v = 0;  r = 1; end
    else if (step_trap)           begin v = 1;  r = 0; end
    else if (brk_trap)            begin v = 3;  r = 0; end
    else if (into_exec && of_flag) begin v = 4; r = 0; end
    else if (bound_fail)          begin v = 5;  r = 1; end
    else if (bad_opcode)          begin v = 6;  r = 1; end
    else if (cop_absent)          begin v = 7;  r = 1; end
    else if (limit_fault)         begin v = 8;  r = 1; end
    else if (word_wrap)           begin v = 13; r = 1; end
    else if (cop_error)           begin v = 16; r = 1; end
    else if (sw_int)              begin v = sw_vec; r = 0; end
    else if (nmi)                 begin v = 2;  r = 0; end
    else if (intr_req && if_flag) begin v = intr_vec; r = 0; end
    else t = 0;
    e_take = t;
    if (t) begin e_vec = v; e_rst = r; end
  endtask

  // one cycle: model the inputs present at the edge, compare at the next negedge
  task automatic tick(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    checks++;
    if (take !== e_take || int'(vec) != e_vec || restart !== e_rst) begin
      fails++;
      $display("FAIL %s: actual take=%0b vec=%0d restart=%0b expected take=%0b vec=%0d restart=%0b",
               tag, take, vec, restart, e_take, e_vec, e_rst);
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R12 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (take !== 0 || vec !== 0 || restart !== 0) begin
      fails++;
      $display("FAIL R12 reset: actual take=%0b vec=%0d restart=%0b expected 0 0 0", take, vec, restart);
    end
    rst_n = 1;
    tick("R12 idle");

    div_zero = 1; tick("R1 divide zero"); clear();
    quot_ovf = 1; tick("R1 quotient overflow"); clear();
    tick("R12 hold after event");
    step_trap = 1; tick("R2 single step"); clear();
    brk_trap = 1; tick("R2 breakpoint"); clear();
    into_exec = 1; of_flag = 1; tick("R3 into with OF"); clear();
    into_exec = 1; tick("R3 into without OF"); clear();
    bound_fail = 1; tick("R4 bound"); clear();
    bad_opcode = 1; tick("R4 opcode"); clear();
    cop_absent = 1; tick("R5 coprocessor absent"); clear();
    limit_fault = 1; tick("R5 table limit"); clear();
    word_wrap = 1; tick("R6 word wrap"); clear();
    cop_error = 1; tick("R7 coprocessor error"); clear();
    sw_int = 1; sw_vec = 8'hC7; tick("R8 software int"); clear();
    nmi = 1; tick("R9 nmi IF clear"); clear();
    nmi = 1; if_flag = 1; tick("R9 nmi IF set"); clear();
    intr_req = 1; intr_vec = 8'h88; tick("R10 intr IF clear"); clear();
    intr_req = 1; if_flag = 1; intr_vec = 8'h88; tick("R10 intr IF set"); clear();
    div_zero = 1; nmi = 1; intr_req = 1; if_flag = 1; tick("R11 div over nmi"); clear();
    nmi = 1; intr_req = 1; if_flag = 1; tick("R11 nmi over intr"); clear();
    bound_fail = 1; bad_opcode = 1; tick("R11 bound over opcode"); clear();
    word_wrap = 1; cop_error = 1; sw_int = 1; tick("R11 wrap over coperr"); clear();
    sw_int = 1; nmi = 1; tick("R11 swint over nmi"); clear();
    step_trap = 1; brk_trap = 1; tick("R11 step over brk"); clear();
    div_zero = 1; tick("R12 back to back a");
    clear(); brk_trap = 1; tick("R12 back to back b"); clear();

    for (int n = 0; n < 2000; n++) begin
      div_zero    = ($urandom % 16) == 0;
      quot_ovf    = ($urandom % 16) == 0;
      step_trap   = ($urandom % 16) == 0;
      brk_trap    = ($urandom % 16) == 0;
      into_exec   = ($urandom % 8) == 0;
      of_flag     = $urandom % 2;
      bound_fail  = ($urandom % 16) == 0;
      bad_opcode  = ($urandom % 16) == 0;
      cop_absent  = ($urandom % 16) == 0;
      limit_fault = ($urandom % 16) == 0;
      word_wrap   = ($urandom % 16) == 0;
      cop_error   = ($urandom % 16) == 0;
      sw_int      = ($urandom % 12) == 0;
      sw_vec      = 8'($urandom);
      nmi         = ($urandom % 8) == 0;
      intr_req    = ($urandom % 3) == 0;
      intr_vec    = 8'($urandom);
      if_flag     = $urandom % 2;
      tick("R11 random mix");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule